// File: doc/BRIEF.md
# Segmented Current-Steering Switch Decoder

This block sits between a digital sample stream and the switch array of a segmented current-steering converter. On each rising clock edge it captures an unsigned 8-bit sample, straight binary with bit 7 as the most significant bit. It splits the sample into a 5-bit coarse field and a 3-bit fine field and expands each field into a thermometer code. The coarse field drives 31 equal segments worth 8 LSB each. The fine field drives 7 equal unit cells worth 1 LSB each, so together they carry seven eighths of one segment.

Every cell has a complementary pair of select lines, one toward output A and one toward output B. While the block is awake, exactly one line of each pair is active. A registered sleep request parks every select line inactive and raises a power-down flag. The captured sample is frozen during sleep, and the block comes back on that sample. The sleep input is meant to be tied or pulled low when it is unused, so the block then stays awake.

A weight output adds up the cells that are steered to A, counting 8 per segment and 1 per unit cell. This lets the bench compare the decoded switch state against the captured sample for every code.

Top module: `seg_dac_decoder`

## Requirements
- R1: `data_i` is sampled only on the rising edge of `clk_i`; the select lines, `pwrdn_o` and `weight_o` change only after that edge and reflect the sample after exactly one edge.
- R2: Coarse select `seg_a_o[k]` (k = 0..30) is high exactly when the captured bits [7:3], read as unsigned, exceed k; the active lines always form a run that starts at line 0.
- R3: Fine select `unit_a_o[j]` (j = 0..6) is high exactly when the captured bits [2:0], read as unsigned, exceed j.
- R4: While awake, every pair is complementary: `seg_b_o == ~seg_a_o` and `unit_b_o == ~unit_a_o`, so no cell is left on neither output.
- R5: Code 255 puts all 38 cells on A and none on B; code 0 puts all 38 cells on B and none on A.
- R6: While awake, `weight_o` equals 8 × (active `seg_a_o` lines) + (active `unit_a_o` lines), which is the captured code; the same weighting over the B lines equals 255 minus the code.
- R7: When `sleep_i` is high at a rising edge, from that edge on all four select buses are zero, `pwrdn_o` is high and `weight_o` is 0; when `sleep_i` is low at an edge, `pwrdn_o` is low after it.
- R8: The sample register does not load at an edge where `sleep_i` is high or at the first low edge that follows a sleep period. In the first awake cycle the block therefore shows the code captured before sleep, and the next edge loads `data_i` again.
- R9: While `rst_ni` is low, with no clock edge needed, the block shows code 0 awake: all cells on B, `pwrdn_o` low, `weight_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Unsigned sample, bit 7 most significant |
| sleep_i | input | 1 | Power-down request, active high |
| seg_a_o | output | 31 | Coarse segment selects toward output A |
| seg_b_o | output | 31 | Coarse segment selects toward output B |
| unit_a_o | output | 7 | Fine unit-cell selects toward output A |
| unit_b_o | output | 7 | Fine unit-cell selects toward output B |
| pwrdn_o | output | 1 | High while the array is powered down |
| weight_o | output | 8 | Weighted count of cells steered to A |

## Verification
Two functions can act at the same edge: leaving sleep and capturing a new sample. The bench presents a fresh code at the same edge that drops `sleep_i`. It expects the first awake cycle to show the code held from before sleep, and the following edge to show the fresh code. It also changes `data_i` during sleep and expects every select line to stay off. Both the release cycle and the cycle after it are checked against values the bench computes from the thermometer and weighting rules.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FINE_W     = 3;
  localparam int unsigned COARSE_W   = DATA_W - FINE_W;
  localparam int unsigned N_SEG      = (1 << COARSE_W) - 1;
  localparam int unsigned N_UNIT     = (1 << FINE_W) - 1;
  localparam int unsigned SEG_WEIGHT = 1 << FINE_W;
endpackage

// File: rtl/seg_dac_capture.sv
module seg_dac_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] code_o,
  output logic              sleep_o
);
  logic load;

  // hold during sleep and for the release edge
  assign load = !sleep_i && !sleep_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      sleep_o <= 1'b0;
    end else begin
      sleep_o <= sleep_i;
      if (load) code_o <= data_i;
    end
  end
endmodule

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
  parameter int unsigned IN_W  = 5,
  localparam int unsigned OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  field_i,
  output logic [OUT_N-1:0] therm_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign therm_o[k] = (field_i > IN_W'(k));
  end
endmodule

// File: rtl/seg_dac_steer.sv
module seg_dac_steer #(
  parameter int unsigned N = 31
) (
  input  logic [N-1:0] therm_i,
  input  logic         sleep_i,
  output logic [N-1:0] a_o,
  output logic [N-1:0] b_o
);
  for (genvar k = 0; k < N; k++) begin : g_pair
    assign a_o[k] = !sleep_i &&  therm_i[k];
    assign b_o[k] = !sleep_i && !therm_i[k];
  end
endmodule

// File: rtl/seg_dac_weight.sv
module seg_dac_weight #(
  parameter int unsigned N_SEG      = 31,
  parameter int unsigned N_UNIT     = 7,
  parameter int unsigned SEG_WEIGHT = 8,
  parameter int unsigned OUT_W      = 8
) (
  input  logic [N_SEG-1:0]  seg_i,
  input  logic [N_UNIT-1:0] unit_i,
  output logic [OUT_W-1:0]  weight_o
);
  always_comb begin
    weight_o = '0;
    for (int k = 0; k < N_SEG; k++)
      if (seg_i[k]) weight_o = weight_o + OUT_W'(SEG_WEIGHT);
    for (int j = 0; j < N_UNIT; j++)
      if (unit_i[j]) weight_o = weight_o + OUT_W'(1);
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned FW = FINE_W,
  localparam int unsigned CW = DW - FW,
  localparam int unsigned NS = (1 << CW) - 1,
  localparam int unsigned NU = (1 << FW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sleep_i,
  output logic [NS-1:0] seg_a_o,
  output logic [NS-1:0] seg_b_o,
  output logic [NU-1:0] unit_a_o,
  output logic [NU-1:0] unit_b_o,
  output logic          pwrdn_o,
  output logic [DW-1:0] weight_o
);
  logic [DW-1:0] code_q;
  logic          sleep_q;
  logic [NS-1:0] seg_therm;
  logic [NU-1:0] unit_therm;

  seg_dac_capture #(.DATA_W(DW)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .sleep_i(sleep_i),
    .code_o(code_q), .sleep_o(sleep_q)
  );

  seg_dac_therm #(.IN_W(CW)) u_seg_dec (
    .field_i(code_q[DW-1:FW]), .therm_o(seg_therm)
  );

  seg_dac_therm #(.IN_W(FW)) u_unit_dec (
    .field_i(code_q[FW-1:0]), .therm_o(unit_therm)
  );

  seg_dac_steer #(.N(NS)) u_seg_sw (
    .therm_i(seg_therm), .sleep_i(sleep_q), .a_o(seg_a_o), .b_o(seg_b_o)
  );

  seg_dac_steer #(.N(NU)) u_unit_sw (
    .therm_i(unit_therm), .sleep_i(sleep_q), .a_o(unit_a_o), .b_o(unit_b_o)
  );

  seg_dac_weight #(
    .N_SEG(NS), .N_UNIT(NU), .SEG_WEIGHT(1 << FW), .OUT_W(DW)
  ) u_wsum (
    .seg_i(seg_a_o), .unit_i(unit_a_o), .weight_o(weight_o)
  );

  assign pwrdn_o = sleep_q;
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned NS = 31,
  parameter int unsigned NU = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] data_i,
  input logic          sleep_i,
  input logic [NS-1:0] seg_a_o,
  input logic [NS-1:0] seg_b_o,
  input logic [NU-1:0] unit_a_o,
  input logic [NU-1:0] unit_b_o,
  input logic          pwrdn_o,
  input logic [DW-1:0] weight_o
);
  // R1
  weight_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !pwrdn_o) |=> (weight_o == $past(data_i)));

  // R2
  seg_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_a_o + NS'(1)) & seg_a_o) == '0);

  // R3
  unit_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((unit_a_o + NU'(1)) & unit_a_o) == '0);

  // R4
  no_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_a_o & seg_b_o) == '0) && ((unit_a_o & unit_b_o) == '0));

  // R4
  all_steered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_o |-> ($countones(seg_a_o) + $countones(seg_b_o) == NS) &&
                 ($countones(unit_a_o) + $countones(unit_b_o) == NU));

  // R7
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> pwrdn_o && (seg_a_o == '0) && (seg_b_o == '0) &&
                (unit_a_o == '0) && (unit_b_o == '0) && (weight_o == '0));

  // R7
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> !pwrdn_o);

  // R8
  release_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && pwrdn_o) |=> !pwrdn_o);
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(.DW(DW), .NS(NS), .NU(NU)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .sleep_i(sleep_i),
  .seg_a_o(seg_a_o), .seg_b_o(seg_b_o), .unit_a_o(unit_a_o),
  .unit_b_o(unit_b_o), .pwrdn_o(pwrdn_o), .weight_o(weight_o)
);

// File: tb/sim_seg_dac_decoder.sv
module sim_seg_dac_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        sleep_i = 1'b0;
  logic [30:0] seg_a_o, seg_b_o;
  logic [6:0]  unit_a_o, unit_b_o;
  logic        pwrdn_o;
  logic [7:0]  weight_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  seg_dac_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .sleep_i(sleep_i),
    .seg_a_o(seg_a_o), .seg_b_o(seg_b_o), .unit_a_o(unit_a_o),
    .unit_b_o(unit_b_o), .pwrdn_o(pwrdn_o), .weight_o(weight_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] seg_exp(input int code);
    logic [30:0] v;
    for (int k = 0; k < 31; k++) v[k] = ((code / 8) > k);
    return v;
  endfunction

  function automatic logic [6:0] unit_exp(input int code);
    logic [6:0] v;
    for (int j = 0; j < 7; j++) v[j] = ((code % 8) > j);
    return v;
  endfunction

  task automatic expect_code(input int code, input string req);
    int wb;
    wb = 8 * $countones(seg_b_o) + $countones(unit_b_o);
    chk(seg_a_o == seg_exp(code), req, "R2 seg_a", int'(seg_a_o), int'(seg_exp(code)));
    chk(unit_a_o == unit_exp(code), req, "R3 unit_a", int'(unit_a_o), int'(unit_exp(code)));
    chk(seg_b_o == ~seg_exp(code) && unit_b_o == ~unit_exp(code), req, "R4 b lines",
        int'(unit_b_o), int'(~unit_exp(code)));
    chk(weight_o == 8'(code), req, "R6 weight_a", int'(weight_o), code);
    chk(wb == 255 - code, req, "R6 weight_b", wb, 255 - code);
    chk(pwrdn_o == 1'b0, req, "R7 awake", int'(pwrdn_o), 0);
  endtask

  task automatic expect_sleep(input string req);
    chk(pwrdn_o == 1'b1, req, "R7 pwrdn", int'(pwrdn_o), 1);
    chk(seg_a_o == '0 && seg_b_o == '0 && unit_a_o == '0 && unit_b_o == '0,
        req, "R7 lines off", int'(seg_a_o | seg_b_o), 0);
    chk(weight_o == '0, req, "R7 weight", int'(weight_o), 0);
  endtask

  // drive at falling edge, sample 5 ns after the rising edge
  task automatic step(input int code, input bit slp);
    @(negedge clk_i);
    data_i  = 8'(code);
    sleep_i = slp;
    @(posedge clk_i);
    #5;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    data_i = 8'hA5;
    #3;
    // R9: reset holds code 0 without any clock edge
    expect_code(0, "R9");
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: output waits for the rising edge
    step(8'h5C, 1'b0);
    @(negedge clk_i);
    data_i = 8'h13;
    #2;
    chk(weight_o == 8'h5C, "R1", "no change before edge", int'(weight_o), 8'h5C);
    @(posedge clk_i);
    #5;
    chk(weight_o == 8'h13, "R1", "update after edge", int'(weight_o), 8'h13);

    // R2 R3 R4 R6: exhaustive sweep
    for (int c = 0; c < 256; c++) begin
      step(c, 1'b0);
      expect_code(c, "R6 sweep");
    end

    // R5 corner codes
    step(255, 1'b0);
    chk(seg_a_o == '1 && unit_a_o == '1 && seg_b_o == '0 && unit_b_o == '0,
        "R5", "all on A", int'(weight_o), 255);
    step(0, 1'b0);
    chk(seg_b_o == '1 && unit_b_o == '1 && seg_a_o == '0 && unit_a_o == '0,
        "R5", "all on B", int'(weight_o), 0);

    // R7 R8: sleep, data ignored, release collides with new data
    step(8'hC9, 1'b0);
    expect_code(8'hC9, "R8 before sleep");
    step(8'h22, 1'b1);
    expect_sleep("R7 enter");
    step(8'h7E, 1'b1);
    expect_sleep("R7 hold");
    step(8'h41, 1'b0);
    expect_code(8'hC9, "R8 release cycle");
    step(8'h41, 1'b0);
    expect_code(8'h41, "R8 after release");

    // R7: single-cycle sleep pulse
    step(8'hFF, 1'b1);
    expect_sleep("R7 pulse");
    step(8'h08, 1'b0);
    expect_code(8'h41, "R8 pulse release");
    step(8'h08, 1'b0);
    expect_code(8'h08, "R8 pulse resume");

    // R9: asynchronous reset mid-run, including out of sleep
    step(8'h9A, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    expect_code(0, "R9 async");
    sleep_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule